// File: doc/BRIEF.md
# Streaming Coefficient Quantizer

The quantizer takes a stream of signed transform coefficients, one per cycle when its input valid flag is high. It divides each one by a step size taken from an internal constant table and emits the rounded quotient, with its own valid flag, exactly four clocks later. There is no backpressure. A new coefficient may arrive on every cycle, or with idle cycles in between, and results leave in arrival order.

The table has two halves of 64 entries: one half for luma and one for chroma. A 2-bit component code that comes with each sample picks the half. The entry inside the half is given by the sample's position in its 64-sample block. The block tracks that position itself with a counter. The counter advances on every accepted sample and returns to zero after the last one. The table contents are computed from closed-form expressions. The luma step at position i is 2*i+1. The chroma step is (5*i) mod 256, so the chroma half includes a zero step and a step of 255.

Top module: `coef_quantizer`

## Requirements
- R1: A synchronous active-high reset clears the output to out_valid=0 and out_data=0 and returns the position counter to 0, so the first sample after reset uses table position 0.
- R2: out_valid in any cycle equals in_valid four cycles earlier. Every accepted sample produces exactly one output.
- R3: out_data equals the signed coefficient divided by the step and rounded to the nearest integer, with exact halves rounded away from zero. Input and output are 12-bit two's complement, and a non-negative coefficient never gives a negative quotient.
- R4: Component codes 0 and 1 select the luma step 2*i+1. Codes 2 and 3 select the chroma step (5*i) mod 256. Here i is the block position of the sample.
- R5: The position counter advances only on cycles with in_valid=1. Idle cycles, whatever in_data and in_comp carry, change neither the counter nor the outputs.
- R6: After the sample at position 63 the counter wraps, and the next sample uses position 0.
- R7: A step of zero produces a quotient of zero.
- R8: Samples presented on consecutive cycles are all accepted, and their results come out on consecutive cycles in the same order.
- R9: out_data is 0 in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input coefficient is valid this cycle |
| in_data | input | 12 | Signed input coefficient |
| in_comp | input | 2 | Component code (0,1 luma; 2,3 chroma) |
| out_valid | output | 1 | Quotient is valid this cycle |
| out_data | output | 12 | Signed rounded quotient |

## Verification
If the position counter slips by even one, the wrong step is used from that sample on. Every later quotient then drifts from the reference, and the drift is visible four cycles after the first misplaced sample. If an idle cycle advances the counter, the mismatch appears on the first valid result after the gap. A luma/chroma select error or a rounding error shows up on the first affected sample. A latency error breaks the valid comparison on the very first output after reset.

// File: rtl/qz_pkg.sv
package qz_pkg;

    localparam int DIV_W    = 8;
    localparam int COMP_W   = 2;
    localparam int PIPE_LAT = 4;

    // Step size for one table half at one block position.
    function automatic logic [DIV_W-1:0] step_entry(input int chroma, input int idx);
        int raw;
        if (chroma != 0) raw = (5 * idx) % 256;
        else             raw = (2 * idx + 1) % 256;
        return DIV_W'(raw);
    endfunction

    // Codes 2 and 3 use the chroma half.
    function automatic logic use_chroma(input logic [COMP_W-1:0] code);
        return code >= COMP_W'(2);
    endfunction

endpackage

// File: rtl/qz_pos_counter.sv
module qz_pos_counter #(
    parameter int BLOCK_LEN = 64,
    localparam int POS_W = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST = POS_W'(BLOCK_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (adv) begin
            if (pos == LAST) pos <= '0;
            else             pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/qz_table_rom.sv
module qz_table_rom #(
    parameter int BLOCK_LEN = 64,
    localparam int POS_W = $clog2(BLOCK_LEN),
    localparam int ENTRIES = 2 * BLOCK_LEN
) (
    input  logic                    chroma,
    input  logic [POS_W-1:0]        pos,
    output logic [qz_pkg::DIV_W-1:0] step
);

    logic [qz_pkg::DIV_W-1:0] table_q [ENTRIES];

    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar i = 0; i < BLOCK_LEN; i++) begin : g_pos
            assign table_q[h*BLOCK_LEN + i] = qz_pkg::step_entry(h, i);
        end
    end

    assign step = table_q[{chroma, pos}];

endmodule

// File: rtl/qz_div_pipe.sv
module qz_div_pipe #(
    parameter int DATA_W = 12,
    localparam int DIV_W = qz_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DIV_W-1:0]  in_step,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic              valid;
        logic              neg;
        logic [DATA_W-1:0] mag;
        logic [DIV_W-1:0]  step;
    } absval_t;

    typedef struct packed {
        logic              valid;
        logic              neg;
        logic              zero;
        logic [DATA_W:0]   num;
        logic [DIV_W:0]    den;
    } frac_t;

    typedef struct packed {
        logic              valid;
        logic              neg;
        logic [DATA_W:0]   quo;
    } quot_t;

    absval_t st1;
    frac_t   st2;
    quot_t   st3;

    logic              in_neg;
    logic [DATA_W-1:0] in_mag;
    logic [DATA_W:0]   quo_neg;
    logic [DATA_W:0]   den_safe;

    assign in_neg   = in_data[DATA_W-1];
    assign in_mag   = in_neg ? (~in_data + 1'b1) : in_data;
    assign quo_neg  = ~st3.quo + 1'b1;
    assign den_safe = st2.zero ? (DATA_W+1)'(1) : (DATA_W+1)'(st2.den);

    // Stage 1: sign and magnitude, capture step.
    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
        end else begin
            st1.valid <= in_valid;
            st1.neg   <= in_neg;
            st1.mag   <= in_mag;
            st1.step  <= in_step;
        end
    end

    // Stage 2: rounding numerator 2|x|+d over denominator 2d.
    always_ff @(posedge clk) begin
        if (rst) begin
            st2 <= '0;
        end else begin
            st2.valid <= st1.valid;
            st2.neg   <= st1.neg;
            st2.zero  <= (st1.step == '0);
            st2.num   <= {st1.mag, 1'b0} + (DATA_W+1)'(st1.step);
            st2.den   <= {st1.step, 1'b0};
        end
    end

    // Stage 3: unsigned division.
    always_ff @(posedge clk) begin
        if (rst) begin
            st3 <= '0;
        end else begin
            st3.valid <= st2.valid;
            st3.neg   <= st2.neg;
            st3.quo   <= st2.zero ? '0 : (st2.num / den_safe);
        end
    end

    // Stage 4: restore sign, zero when idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= st3.valid;
            if (!st3.valid)  out_data <= '0;
            else if (st3.neg) out_data <= quo_neg[DATA_W-1:0];
            else              out_data <= st3.quo[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer #(
    parameter int DATA_W    = 12,
    parameter int BLOCK_LEN = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    input  logic [qz_pkg::COMP_W-1:0] in_comp,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data
);

    localparam int POS_W = $clog2(BLOCK_LEN);

    logic [POS_W-1:0]         pos_q;
    logic [qz_pkg::DIV_W-1:0] lut_step;
    logic                     chroma_sel;

    assign chroma_sel = qz_pkg::use_chroma(in_comp);

    qz_pos_counter #(.BLOCK_LEN(BLOCK_LEN)) u_pos (
        .clk (clk),
        .rst (rst),
        .adv (in_valid),
        .pos (pos_q)
    );

    qz_table_rom #(.BLOCK_LEN(BLOCK_LEN)) u_rom (
        .chroma (chroma_sel),
        .pos    (pos_q),
        .step   (lut_step)
    );

    qz_div_pipe #(.DATA_W(DATA_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_step   (lut_step),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/qz_checker.sv
module qz_checker #(
    parameter int DATA_W    = 12,
    parameter int BLOCK_LEN = 64,
    localparam int POS_W = $clog2(BLOCK_LEN)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [DATA_W-1:0]         in_data,
    input logic [qz_pkg::COMP_W-1:0] in_comp,
    input logic                      out_valid,
    input logic [DATA_W-1:0]         out_data,
    input logic [POS_W-1:0]          pos,
    input logic [qz_pkg::DIV_W-1:0]  step
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    assert_pos_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd1 && !in_valid) |=> $stable(pos));

    assert_pos_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pos == POS_W'(BLOCK_LEN - 1)) |=> (pos == '0));

    assert_zero_step_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && step == '0) |-> ##4 (out_data == '0));

    assert_sign_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_data[DATA_W-1]) |-> ##4 !out_data[DATA_W-1]);

    assert_luma_odd_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_comp < 2'd2) |-> step[0]);

endmodule

bind coef_quantizer qz_checker #(.DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN)) u_qz_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_comp   (in_comp),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pos       (pos_q),
    .step      (lut_step)
);

// File: tb/coef_quantizer_tb.sv
module coef_quantizer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic [1:0]  in_comp = '0;
    logic        out_valid;
    logic [11:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mpos = 0;
    bit finished = 0;
    string cur_tag = "R3";

    bit    exp_v   [4096];
    int    exp_d   [4096];
    string exp_tag [4096];

    always #5 clk = ~clk;

    coef_quantizer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_comp(in_comp), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int step_of(int comp, int p);
        if (comp >= 2) return (5 * p) % 256;
        return 2 * p + 1;
    endfunction

    function automatic int qref(int x, int d);
        int m, q;
        if (d == 0) return 0;
        m = (x < 0) ? -x : x;
        q = (2 * m + d) / (2 * d);
        return (x < 0) ? -q : q;
    endfunction

    function automatic int pattern(int k);
        return ((k * 1237 + 311) % 4096) - 2048;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, expv);
        end
    endtask

    task automatic step(input bit v, input int x, input int comp, input bit r);
        int d;
        @(negedge clk);
        check("R2", int'(out_valid), int'(exp_v[cyc]));
        if (exp_v[cyc]) check(exp_tag[cyc], $signed(out_data), exp_d[cyc]);
        else            check("R9", int'(out_data), 0);
        rst      = r;
        in_valid = v;
        in_data  = 12'(x);
        in_comp  = 2'(comp);
        exp_v[cyc+4] = 1'b0;
        if (r) begin
            mpos = 0;
            for (int j = 1; j <= 4; j++) exp_v[cyc+j] = 1'b0;
        end else if (v) begin
            d = step_of(comp, mpos);
            exp_v[cyc+4]   = 1'b1;
            exp_d[cyc+4]   = qref(x, d);
            exp_tag[cyc+4] = (d == 0) ? "R7" : cur_tag;
            mpos = (mpos + 1) % 64;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) step(1'b0, 12'h5A5, 3, 1'b0);
    endtask

    initial begin
        int k, n, x, d;
        for (int j = 0; j < 4; j++) step(1'b0, 0, 0, 1'b1);
        step(1'b0, 0, 0, 1'b0);
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_data), 0);

        // back-to-back luma block
        cur_tag = "R8";
        for (int j = 0; j < 64; j++) step(1'b1, pattern(j), 0, 1'b0);
        idle(3);

        // chroma block with gaps and exact halves
        cur_tag = "R5";
        k = 0; n = 0;
        while (n < 64) begin
            if (k % 3 == 1) begin
                step(1'b0, 12'h7FF, 0, 1'b0);
            end else begin
                d = step_of(2, mpos);
                if (d % 2 == 0 && d != 0 && (n % 2 == 0)) x = (d / 2) * 3;
                else if (d % 2 == 0 && d != 0)            x = -(d / 2) * 5;
                else                                      x = pattern(k + 100);
                step(1'b1, x, 2, 1'b0);
                n++;
            end
            k++;
        end

        // alternating codes 3 and 1, crossing the wrap
        for (int j = 0; j < 70; j++) begin
            cur_tag = (j >= 64) ? "R6" : "R4";
            step(1'b1, pattern(j + 500), (j % 2 == 0) ? 3 : 1, 1'b0);
        end
        idle(6);

        // extremes with small luma steps
        cur_tag = "R3";
        step(1'b1, -2048, 0, 1'b0);
        step(1'b1, 2047, 0, 1'b0);
        step(1'b1, -1, 1, 1'b0);
        step(1'b1, 0, 0, 1'b0);
        step(1'b1, 1, 1, 1'b0);
        step(1'b1, -2048, 2, 1'b0);
        step(1'b1, 2047, 3, 1'b0);
        idle(6);

        // reset mid-block, position must restart
        cur_tag = "R8";
        for (int j = 0; j < 5; j++) step(1'b1, pattern(j + 900), 0, 1'b0);
        step(1'b0, 0, 0, 1'b1);
        step(1'b0, 0, 0, 1'b1);
        cur_tag = "R1";
        for (int j = 0; j < 5; j++) step(1'b1, 1000 - 37 * j, 0, 1'b0);
        idle(6);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog cycle %0d actual hung expected done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule